// File: doc/BRIEF.md
# Time-Scheduled Periodic Trigger Generator

The block emits a single-clock trigger pulse that is locked to a distributed time base. The time base consists of a coarse count of whole seconds, a fine count that runs within each second, and a tick that marks the start of every second. Nothing is emitted until the coarse count reaches a programmed start second. From then on, the block fires once every N seconds, at the point in the second where the fine count equals a programmed offset.

A bypass input hands the output over to the raw second tick. A restart input re-arms the schedule, so that a new start second takes effect. All settings are plain level inputs that a register bank elsewhere in the chip holds. The output is registered and lags its cause by one clock.

Top module: `sched_trigger`

## Requirements
- R1: While rst_n is low, trig_o is 0, and all schedule state returns to the unarmed condition.
- R2: With bypass_i low and the schedule unarmed, trig_o stays 0 in every second whose coarse count is below start_sec_i.
- R3: The first pulse falls in the second whose coarse count equals start_sec_i. It is raised one clock after the first clock on which fine_i equals phase_i.
- R4: Once the schedule is armed, a pulse occurs in each second where (coarse − start_sec_i) mod P is 0, at the same fine offset. P equals period_i, except that a period_i of 0 acts as 1.
- R5: A scheduled pulse lasts exactly one clock, even while fine_i holds the matching value for several clocks.
- R6: While bypass_i is high, trig_o equals sec_tick_i as it was one clock earlier. The schedule keeps running underneath.
- R7: A rising edge on restart_i clears the armed state and the seconds phase, and the block waits for start_sec_i again. Holding restart_i high has no further effect, and no pulse is raised on the clock of the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick_i | input | 1 | One-clock marker at the start of each second |
| coarse_i | input | CT_W (32) | Seconds count of the time base |
| fine_i | input | FT_W (16) | Sub-second count, zero at each tick |
| period_i | input | PER_W (4) | Trigger period in seconds, 0 acts as 1 |
| phase_i | input | FT_W (16) | Fine-count offset of the pulse within its second |
| start_sec_i | input | CT_W (32) | Coarse count at which scheduling begins |
| restart_i | input | 1 | Re-arm request, acts on its rising edge |
| bypass_i | input | 1 | Route the second tick to the output |
| trig_o | output | 1 | Trigger pulse |

## Verification
The assertions rely on several properties of the time base. sec_tick_i is a one-clock pulse on the clock where coarse_i has just advanced and fine_i has gone back to zero. fine_i holds each value for several clocks. The schedule settings change only together with a restart edge, at a time when coarse_i is still below the new start second. The bench builds its own time base with these properties: three clocks per fine step and twenty steps per second. It raises restart only alongside new settings and a start second one to three seconds ahead. It toggles bypass only on second boundaries.

// File: rtl/sched_trigger.sv
module sched_trigger #(
  parameter int CT_W  = 32,
  parameter int FT_W  = 16,
  parameter int PER_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick_i,
  input  logic [CT_W-1:0]  coarse_i,
  input  logic [FT_W-1:0]  fine_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [FT_W-1:0]  phase_i,
  input  logic [CT_W-1:0]  start_sec_i,
  input  logic             restart_i,
  input  logic             bypass_i,
  output logic             trig_o
);

  logic             armed, restart_q, hit_q;
  logic [PER_W-1:0] sec_ph, sec_ph_now, ph_last;
  logic             restart_rise, due, hit, fire;

  assign ph_last      = (period_i == '0) ? '0 : period_i - 1'b1;
  assign restart_rise = restart_i && !restart_q;
  assign sec_ph_now   = (armed && sec_tick_i) ? ((sec_ph >= ph_last) ? '0 : sec_ph + 1'b1) : sec_ph;
  assign due          = armed ? (sec_ph_now == '0) : (coarse_i == start_sec_i);
  assign hit          = due && (fine_i == phase_i);
  assign fire         = hit && !hit_q && !restart_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      restart_q <= 1'b0;
      hit_q     <= 1'b0;
      sec_ph    <= '0;
      trig_o    <= 1'b0;
    end else begin
      restart_q <= restart_i;
      hit_q     <= hit;
      trig_o    <= bypass_i ? sec_tick_i : fire;
      if (restart_rise) begin
        armed  <= 1'b0;
        sec_ph <= '0;
      end else if (fire && !armed) begin
        armed  <= 1'b1;
        sec_ph <= '0;
      end else begin
        sec_ph <= sec_ph_now;
      end
    end
  end

  p_reset_low_r1: assert property (@(posedge clk) !rst_n |-> !trig_o);

  p_quiet_before_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!armed) && $past(!bypass_i) && $past(coarse_i < start_sec_i) |-> !trig_o);

  p_first_at_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && trig_o && $past(!bypass_i) && $past(!armed)
    |-> $past(coarse_i == start_sec_i) && $past(fine_i == phase_i));

  p_phase_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!restart_i) && $stable(period_i) |-> sec_ph <= ph_last);

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && trig_o && $past(!bypass_i) |=> !trig_o || $past(bypass_i));

  p_bypass_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(bypass_i) |-> trig_o == $past(sec_tick_i));

  p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $rose(restart_i) |=> !armed);

endmodule

// File: tb/test_sched_trigger.sv
module test_sched_trigger;
  localparam int FMAX = 20;
  localparam int HOLD = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick_i = 1'b0;
  logic [31:0] coarse_i = '0;
  logic [15:0] fine_i = '0;
  logic [3:0]  period_i = '0;
  logic [15:0] phase_i = '0;
  logic [31:0] start_sec_i = '0;
  logic        restart_i = 1'b0;
  logic        bypass_i = 1'b0;
  logic        trig_o;

  always #10 clk = ~clk;

  sched_trigger i_sched_trigger (
    .clk(clk), .rst_n(rst_n), .sec_tick_i(sec_tick_i), .coarse_i(coarse_i),
    .fine_i(fine_i), .period_i(period_i), .phase_i(phase_i),
    .start_sec_i(start_sec_i), .restart_i(restart_i), .bypass_i(bypass_i),
    .trig_o(trig_o));

  int unsigned c = 100, s_v = 0;
  int f = 0, hold = 0, p_v = 0, h_v = 0;
  bit tick = 0, rs_v = 0, byp_v = 0, byp_mix = 0, done = 0;
  bit exp_q = 0;
  string tag_q = "R1";
  int errors = 0, checks = 0;

  function automatic bit model(int unsigned cc, int ff, bit first, bit tk, bit byp,
                               int unsigned ss, int pp, int hh);
    int unsigned pe;
    pe = (pp == 0) ? 1 : pp;
    if (byp) return tk;
    return first && (ff == hh) && (cc >= ss) && (((cc - ss) % pe) == 0);
  endfunction

  task automatic drive_and_predict();
    sec_tick_i  = tick;
    coarse_i    = c;
    fine_i      = 16'(f);
    period_i    = 4'(p_v);
    phase_i     = 16'(h_v);
    start_sec_i = s_v;
    restart_i   = rs_v;
    bypass_i    = byp_v;
    exp_q = model(c, f, hold == 0, tick, byp_v, s_v, p_v, h_v);
    if (byp_v)                 tag_q = "R6";
    else if (rs_v && c <= s_v) tag_q = "R7";
    else if (exp_q && c == s_v) tag_q = "R3";
    else if (exp_q)            tag_q = "R4";
    else if (c < s_v)          tag_q = "R2";
    else                       tag_q = "R5";
  endtask

  task automatic step();
    @(negedge clk);
    checks++;
    if (trig_o !== exp_q) begin
      errors++;
      $display("FAIL %s trig=%0b expected=%0b coarse=%0d fine=%0d start=%0d period=%0d",
               tag_q, trig_o, exp_q, c, f, s_v, p_v);
    end
    tick = 0;
    hold++;
    if (hold == HOLD) begin
      hold = 0;
      f++;
      if (f == FMAX) begin
        f = 0;
        c++;
        tick = 1;
        if (byp_mix) byp_v = ($urandom % 3) == 0;
      end
    end
    drive_and_predict();
  endtask

  task automatic scenario(int pp, int hh, bit mix);
    int unsigned endc;
    rs_v = 0;
    step();
    p_v = pp; h_v = hh; byp_mix = mix; byp_v = 0;
    s_v = c + 1 + ($urandom % 3);
    rs_v = 1;
    endc = s_v + 2 * ((pp == 0) ? 1 : pp) + 2;
    while (c < endc) step();
    byp_mix = 0; byp_v = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    s_v = c + 2; p_v = 3; h_v = 5;
    drive_and_predict();
    sec_tick_i = 1'b1; bypass_i = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (trig_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 trig=%0b expected=0 during reset", trig_o);
    end
    rst_n = 1'b1;
    drive_and_predict();
    while (c < s_v + 8) step();
    scenario(0, 0, 0);
    scenario(15, FMAX - 1, 0);
    scenario(1, 7, 1);
    scenario(2, 0, 1);
    for (int k = 0; k < 6; k++) scenario(int'($urandom % 8), int'($urandom % FMAX), k[0]);
    repeat (5) step();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20ns * 150000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule